// File: doc/BRIEF.md
# Processor Program Trace Capture Unit

This block watches the retirement stream of a small 32-bit processor and records selected events into an internal circular buffer that a debugger can read back afterwards. Every retirement carries a valid strobe, the new program counter, flags for taken branch, call, return and load/get, the loaded data word, and a vector of comparator hits from breakpoints and watchpoints.

Two write-only registers steer the unit. The control register holds a two-bit compression level, three save filters, a halt-on-full enable and a per-comparator mask that turns a hit into a recorded tracepoint instead of a stop. The command register clears the buffer, starts or stops capture, and samples the number of stored items into an output register. Up to four items can come from one retirement. They are written in one cycle, in a fixed order.

Top module: `trace_capture`

## Requirements
- R1: After reset the sampled item count, the halt request and the breakpoint stop are 0. Capture is stopped. The control fields are zero, which selects level 0 with every filter off.
- R2: The command word uses bit 0 for clear, bit 1 for start, bit 2 for stop and bit 3 for sample. Clear empties the buffer, resets the cycle counter, drops the overflow flag and the halt request, and causes start or stop in the same word to be ignored. Stop wins over start. Retirements are stored only while capture is running.
- R3: A sample command loads the item count, as it stood before that command, into `item_count`, where it is visible after the next clock edge.
- R4: The control layout is: bit 0 save return, bit 1 save load, bit 2 save PC, bit 3 halt on full, bits 5:4 level, bits 6 and up the tracepoint mask. At level 0, every retirement stores a PC item (kind 0) whose payload is the new PC.
- R5: Save PC stores a PC item for each taken branch at levels 1 and 3. At level 2 it stores one only for calls.
- R6: At levels 1, 2 and 3, save return stores a PC item for each return.
- R7: At any level, save load stores a data item (kind 1) whose payload is the loaded value, for every load/get retirement.
- R8: At level 3 each stored PC item is preceded by a cycle item (kind 2). Its payload is the number of running cycles since the previous PC item, after which the counter restarts at 0. The counter saturates at its maximum. A further increment past the maximum sets a sticky overflow flag.
- R9: A retirement whose comparator hit falls on a set mask bit stores a tracepoint item (kind 3) whose payload is the PC. A hit on a clear mask bit raises `brk_halt` in the next cycle and stores nothing.
- R10: The buffer holds DEPTH items. With halt on full clear, it overwrites the oldest item once full. Read index 0 addresses the oldest item. Read data appears one cycle after `rd_en`.
- R11: With halt on full set, items beyond DEPTH are discarded. `halt_req` rises in the cycle the buffer becomes full or the cycle counter overflows, and stays high until a clear.
- R12: When one retirement produces several items, they are stored in the order cycle, PC, data, tracepoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 32 | Control register write data |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command register write data |
| ret_valid | input | 1 | Retirement valid |
| ret_pc | input | 32 | New program counter |
| ret_taken | input | 1 | Taken branch |
| ret_call | input | 1 | Function call |
| ret_return | input | 1 | Return instruction |
| ret_load | input | 1 | Load or get instruction |
| ret_ldata | input | 32 | Loaded data value |
| cmp_hit | input | TP_W | Breakpoint/watchpoint hit vector |
| rd_en | input | 1 | Buffer read request |
| rd_idx | input | AW | Read index, 0 = oldest |
| rd_kind | output | 2 | Item kind of the read entry |
| rd_payload | output | 32 | Payload of the read entry |
| item_count | output | CW | Sampled item count |
| halt_req | output | 1 | Debug halt request (full or overflow) |
| brk_halt | output | 1 | Stop request from a non-tracepoint hit |

## Verification
The cases that are hardest to reach from the ports are cycle counter overflow and the moment the buffer becomes full. The bench builds a small instance with a 16-entry buffer and an 8-bit counter. It idles exactly 255 running cycles, checks that the halt request is still low, and then idles one more cycle. For the full case, it counts retirements up to the fifteenth and then the sixteenth. The save filters and levels are swept exhaustively against every flag combination, and the buffer is read back after each setting.

// File: rtl/trace_pkg.sv
package trace_pkg;

   localparam int NSLOT = 4;

   // slot order inside one retirement: cycle, PC, data, tracepoint
   localparam int SLOT_CYC  = 0;
   localparam int SLOT_PC   = 1;
   localparam int SLOT_DATA = 2;
   localparam int SLOT_TP   = 3;

   typedef enum logic [1:0] {
      ITEM_PC   = 2'd0,
      ITEM_DATA = 2'd1,
      ITEM_CYC  = 2'd2,
      ITEM_TP   = 2'd3
   } item_kind_e;

   typedef enum logic [1:0] {
      LVL_FULL    = 2'd0,
      LVL_FLOW    = 2'd1,
      LVL_EVENT   = 2'd2,
      LVL_FLOWCYC = 2'd3
   } trace_level_e;

   typedef struct packed {
      item_kind_e  kind;
      logic [31:0] payload;
   } trace_item_t;

endpackage

// File: rtl/trace_cmd_regs.sv
module trace_cmd_regs
   import trace_pkg::*;
#(
   parameter int TP_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [31:0]       ctrl_wdata,
   input  logic              cmd_we,
   input  logic [31:0]       cmd_wdata,
   output trace_level_e      level,
   output logic              save_ret,
   output logic              save_load,
   output logic              save_pc,
   output logic              hold_full,
   output logic [TP_W-1:0]   tp_mask,
   output logic              running,
   output logic              clr,
   output logic              smp
);

   localparam int CTRL_W = 6 + TP_W;

   logic [CTRL_W-1:0] ctrl_q;
   logic              run_q;
   logic              go, halt_cmd;
   logic              unused_bits;

   assign unused_bits = ^{ctrl_wdata[31:CTRL_W], cmd_wdata[31:4]};

   assign clr      = cmd_we & cmd_wdata[0];
   assign go       = cmd_we & cmd_wdata[1] & ~clr;
   assign halt_cmd = cmd_we & cmd_wdata[2] & ~clr;
   assign smp      = cmd_we & cmd_wdata[3];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         run_q  <= 1'b0;
      end else begin
         if (ctrl_we)
            ctrl_q <= ctrl_wdata[CTRL_W-1:0];
         if (halt_cmd)
            run_q <= 1'b0;
         else if (go)
            run_q <= 1'b1;
      end
   end

   assign save_ret  = ctrl_q[0];
   assign save_load = ctrl_q[1];
   assign save_pc   = ctrl_q[2];
   assign hold_full = ctrl_q[3];
   assign level     = trace_level_e'(ctrl_q[5:4]);
   assign tp_mask   = ctrl_q[CTRL_W-1:6];
   assign running   = run_q;

endmodule

// File: rtl/trace_event_sel.sv
module trace_event_sel
   import trace_pkg::*;
#(
   parameter int TP_W  = 16,
   parameter int CYC_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              running,
   input  logic              clr,
   input  trace_level_e      level,
   input  logic              save_ret,
   input  logic              save_load,
   input  logic              save_pc,
   input  logic [TP_W-1:0]   tp_mask,
   input  logic              ret_valid,
   input  logic [31:0]       ret_pc,
   input  logic              ret_taken,
   input  logic              ret_call,
   input  logic              ret_return,
   input  logic              ret_load,
   input  logic [31:0]       ret_ldata,
   input  logic [TP_W-1:0]   cmp_hit,
   output logic [NSLOT-1:0]  req,
   output trace_item_t       items [NSLOT],
   output logic              brk_hit,
   output logic              ovf_d
);

   localparam logic [CYC_W-1:0] CYC_MAX = '1;

   logic             cap, flow, tp_hit, cnt_en;
   logic [CYC_W-1:0] cyc_q;
   logic             ovf_q;

   assign cap = running & ret_valid & ~clr;

   always_comb begin
      flow = 1'b0;
      unique case (level)
         LVL_FULL:              flow = 1'b1;
         LVL_FLOW, LVL_FLOWCYC: flow = (save_pc & ret_taken) | (save_ret & ret_return);
         LVL_EVENT:             flow = (save_pc & ret_call)  | (save_ret & ret_return);
         default:               flow = 1'b0;
      endcase
   end

   assign tp_hit  = |(cmp_hit & tp_mask);
   assign brk_hit = ret_valid & (|(cmp_hit & ~tp_mask));

   assign req[SLOT_CYC]  = cap & flow & (level == LVL_FLOWCYC);
   assign req[SLOT_PC]   = cap & flow;
   assign req[SLOT_DATA] = cap & save_load & ret_load;
   assign req[SLOT_TP]   = cap & tp_hit;

   always_comb begin
      items[SLOT_CYC]  = '{kind: ITEM_CYC,  payload: 32'(cyc_q)};
      items[SLOT_PC]   = '{kind: ITEM_PC,   payload: ret_pc};
      items[SLOT_DATA] = '{kind: ITEM_DATA, payload: ret_ldata};
      items[SLOT_TP]   = '{kind: ITEM_TP,   payload: ret_pc};
   end

   // cycle counter between program-flow items, level 3 only
   assign cnt_en = running & (level == LVL_FLOWCYC) & ~clr;
   assign ovf_d  = ~clr & (ovf_q | (cnt_en & ~req[SLOT_CYC] & (cyc_q == CYC_MAX)));

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cyc_q <= '0;
         ovf_q <= 1'b0;
      end else if (cnt_en) begin
         if (req[SLOT_CYC])
            cyc_q <= '0;
         else if (cyc_q == CYC_MAX)
            ovf_q <= 1'b1;
         else
            cyc_q <= cyc_q + 1'b1;
      end
   end

endmodule

// File: rtl/trace_ring.sv
module trace_ring
   import trace_pkg::*;
#(
   parameter  int DEPTH = 64,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             hold_full,
   input  logic [NSLOT-1:0] req,
   input  trace_item_t      items [NSLOT],
   input  logic             rd_en,
   input  logic [AW-1:0]    rd_idx,
   output logic [CW-1:0]    cnt,
   output logic [CW-1:0]    cnt_d,
   output trace_item_t      rd_item
);

   trace_item_t      mem [DEPTH];
   logic [AW-1:0]    wptr_q, wptr_d, oldest;
   logic [CW-1:0]    cnt_q;
   logic [NSLOT-1:0] wen;
   logic [AW-1:0]    waddr [NSLOT];
   trace_item_t      rd_q;

   // each slot lands after the slots of lower order requested this cycle
   always_comb begin
      int seen;
      int nwr;
      int total;
      seen = 0;
      nwr  = 0;
      for (int k = 0; k < NSLOT; k++) begin
         waddr[k] = wptr_q + AW'(seen);
         wen[k]   = req[k] && (!hold_full || (int'(cnt_q) + seen < DEPTH));
         if (req[k]) seen = seen + 1;
         if (wen[k]) nwr  = nwr + 1;
      end
      total = int'(cnt_q) + nwr;
      if (clr) begin
         cnt_d  = '0;
         wptr_d = '0;
      end else begin
         cnt_d  = (total > DEPTH) ? CW'(DEPTH) : CW'(total);
         wptr_d = wptr_q + AW'(nwr);
      end
   end

   always_ff @(posedge clk) begin
      for (int k = 0; k < NSLOT; k++)
         if (wen[k])
            mem[waddr[k]] <= items[k];
   end

   assign oldest = wptr_q - cnt_q[AW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr_q <= '0;
         cnt_q  <= '0;
         rd_q   <= '0;
      end else begin
         wptr_q <= wptr_d;
         cnt_q  <= cnt_d;
         if (rd_en)
            rd_q <= mem[oldest + rd_idx];
      end
   end

   assign cnt     = cnt_q;
   assign rd_item = rd_q;

endmodule

// File: rtl/trace_capture.sv
module trace_capture
   import trace_pkg::*;
#(
   parameter  int DEPTH = 64,
   parameter  int TP_W  = 16,
   parameter  int CYC_W = 16,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ctrl_we,
   input  logic [31:0]     ctrl_wdata,
   input  logic            cmd_we,
   input  logic [31:0]     cmd_wdata,
   input  logic            ret_valid,
   input  logic [31:0]     ret_pc,
   input  logic            ret_taken,
   input  logic            ret_call,
   input  logic            ret_return,
   input  logic            ret_load,
   input  logic [31:0]     ret_ldata,
   input  logic [TP_W-1:0] cmp_hit,
   input  logic            rd_en,
   input  logic [AW-1:0]   rd_idx,
   output logic [1:0]      rd_kind,
   output logic [31:0]     rd_payload,
   output logic [CW-1:0]   item_count,
   output logic            halt_req,
   output logic            brk_halt
);

   // elaboration-time parameter checks
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("trace_capture: DEPTH must be a power of two of at least 4");
   end
   if (TP_W < 1 || TP_W > 24) begin : g_bad_tp
      $error("trace_capture: TP_W must lie in 1..24");
   end
   if (CYC_W < 2 || CYC_W > 32) begin : g_bad_cyc
      $error("trace_capture: CYC_W must lie in 2..32");
   end

   trace_level_e     level;
   logic             save_ret, save_load, save_pc, hold_full;
   logic [TP_W-1:0]  tp_mask;
   logic             running, clr, smp;
   logic [NSLOT-1:0] req;
   trace_item_t      items [NSLOT];
   logic             brk_hit, ovf_d;
   logic [CW-1:0]    cnt_q, cnt_d;
   trace_item_t      rd_item;
   logic [CW-1:0]    smp_q;
   logic             halt_q, brk_q;

   trace_cmd_regs #(.TP_W(TP_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_we    (ctrl_we),
      .ctrl_wdata (ctrl_wdata),
      .cmd_we     (cmd_we),
      .cmd_wdata  (cmd_wdata),
      .level      (level),
      .save_ret   (save_ret),
      .save_load  (save_load),
      .save_pc    (save_pc),
      .hold_full  (hold_full),
      .tp_mask    (tp_mask),
      .running    (running),
      .clr        (clr),
      .smp        (smp)
   );

   trace_event_sel #(.TP_W(TP_W), .CYC_W(CYC_W)) u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .running    (running),
      .clr        (clr),
      .level      (level),
      .save_ret   (save_ret),
      .save_load  (save_load),
      .save_pc    (save_pc),
      .tp_mask    (tp_mask),
      .ret_valid  (ret_valid),
      .ret_pc     (ret_pc),
      .ret_taken  (ret_taken),
      .ret_call   (ret_call),
      .ret_return (ret_return),
      .ret_load   (ret_load),
      .ret_ldata  (ret_ldata),
      .cmp_hit    (cmp_hit),
      .req        (req),
      .items      (items),
      .brk_hit    (brk_hit),
      .ovf_d      (ovf_d)
   );

   trace_ring #(.DEPTH(DEPTH)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .hold_full (hold_full),
      .req       (req),
      .items     (items),
      .rd_en     (rd_en),
      .rd_idx    (rd_idx),
      .cnt       (cnt_q),
      .cnt_d     (cnt_d),
      .rd_item   (rd_item)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         smp_q  <= '0;
         halt_q <= 1'b0;
         brk_q  <= 1'b0;
      end else begin
         if (smp)
            smp_q <= cnt_q;
         if (clr)
            halt_q <= 1'b0;
         else
            halt_q <= halt_q | (hold_full & ((cnt_d == CW'(DEPTH)) | ovf_d));
         brk_q <= brk_hit;
      end
   end

   assign item_count = smp_q;
   assign halt_req   = halt_q;
   assign brk_halt   = brk_q;
   assign rd_kind    = rd_item.kind;
   assign rd_payload = rd_item.payload;

endmodule

// File: rtl/trace_capture_chk.sv
module trace_capture_chk #(
   parameter  int DEPTH = 64,
   parameter  int TP_W  = 16,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cmd_we,
   input logic [3:0]      cmd_bits,
   input logic            ret_valid,
   input logic [TP_W-1:0] cmp_hit,
   input logic [TP_W-1:0] tp_mask,
   input logic            running,
   input logic [CW-1:0]   cnt,
   input logic [CW-1:0]   item_count,
   input logic            halt_req,
   input logic            brk_halt
);

   // R10
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));

   // R3
   sample_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && cmd_bits[3]) |=> (item_count == $past(cnt)));

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !(cmd_we && cmd_bits[0])) |=> (cnt == $past(cnt)));

   // R2
   clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && cmd_bits[0]) |=> (cnt == '0 && !halt_req));

   // R11
   halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_req && !(cmd_we && cmd_bits[0])) |=> halt_req);

   // R9
   brk_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid && |(cmp_hit & ~tp_mask)) |=> brk_halt);

endmodule

bind trace_capture trace_capture_chk #(.DEPTH(DEPTH), .TP_W(TP_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_we     (cmd_we),
   .cmd_bits   (cmd_wdata[3:0]),
   .ret_valid  (ret_valid),
   .cmp_hit    (cmp_hit),
   .tp_mask    (tp_mask),
   .running    (running),
   .cnt        (cnt_q),
   .item_count (item_count),
   .halt_req   (halt_req),
   .brk_halt   (brk_halt)
);

// File: tb/trace_capture_tb.sv
module trace_capture_tb;

   localparam int DEPTH = 16;
   localparam int TP_W  = 16;
   localparam int CYC_W = 8;
   localparam int AW    = $clog2(DEPTH);
   localparam int CW    = $clog2(DEPTH + 1);
   localparam int CMAX  = (1 << CYC_W) - 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            ctrl_we = 1'b0;
   logic [31:0]     ctrl_wdata = '0;
   logic            cmd_we = 1'b0;
   logic [31:0]     cmd_wdata = '0;
   logic            ret_valid = 1'b0;
   logic [31:0]     ret_pc = '0;
   logic            ret_taken = 1'b0, ret_call = 1'b0, ret_return = 1'b0, ret_load = 1'b0;
   logic [31:0]     ret_ldata = '0;
   logic [TP_W-1:0] cmp_hit = '0;
   logic            rd_en = 1'b0;
   logic [AW-1:0]   rd_idx = '0;
   logic [1:0]      rd_kind;
   logic [31:0]     rd_payload;
   logic [CW-1:0]   item_count;
   logic            halt_req, brk_halt;

   trace_capture #(.DEPTH(DEPTH), .TP_W(TP_W), .CYC_W(CYC_W)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
      .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_taken(ret_taken),
      .ret_call(ret_call), .ret_return(ret_return), .ret_load(ret_load),
      .ret_ldata(ret_ldata), .cmp_hit(cmp_hit),
      .rd_en(rd_en), .rd_idx(rd_idx), .rd_kind(rd_kind), .rd_payload(rd_payload),
      .item_count(item_count), .halt_req(halt_req), .brk_halt(brk_halt)
   );

   always #2 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // expected-state model built from the requirements
   int       mk [1024];
   int       mp [1024];
   int       mtot = 0, mcnt = 0;
   int       lvl = 0, sv = 0, fh = 0, mask = 0;
   int       cyc_e = 0, ovf_e = 0, run_e = 0, halt_e = 0, smp_e = 0;

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic push(input int k, input int p);
      if (fh != 0 && mcnt >= DEPTH) return;
      mk[mtot % 1024] = k;
      mp[mtot % 1024] = p;
      mtot++;
      if (mcnt < DEPTH) mcnt++;
   endtask

   task automatic tick(input bit flow);
      if (run_e != 0 && lvl == 3) begin
         if (flow) cyc_e = 0;
         else if (cyc_e == CMAX) ovf_e = 1;
         else cyc_e++;
      end
      if (fh != 0 && (mcnt == DEPTH || ovf_e != 0)) halt_e = 1;
   endtask

   task automatic wr_ctrl(input int l, input int s, input int f, input int m);
      ctrl_we = 1'b1;
      ctrl_wdata = (m << 6) | (l << 4) | (f << 3) | s;
      @(negedge clk);
      ctrl_we = 1'b0;
      tick(1'b0);
      lvl = l; sv = s; fh = f; mask = m;
   endtask

   task automatic wr_cmd(input int v);
      cmd_we = 1'b1;
      cmd_wdata = v;
      @(negedge clk);
      cmd_we = 1'b0;
      if (v[3]) smp_e = mcnt;
      if (v[0]) begin
         mtot = 0; mcnt = 0; cyc_e = 0; ovf_e = 0; halt_e = 0;
      end else begin
         tick(1'b0);
         if (v[2]) run_e = 0;
         else if (v[1]) run_e = 1;
      end
   endtask

   task automatic retire(input int pc, input bit tk, input bit cl, input bit rt,
                         input bit ld, input int ldv, input int hit);
      bit flow;
      ret_valid = 1'b1; ret_pc = pc; ret_taken = tk; ret_call = cl;
      ret_return = rt; ret_load = ld; ret_ldata = ldv; cmp_hit = hit[TP_W-1:0];
      @(negedge clk);
      ret_valid = 1'b0; ret_taken = 1'b0; ret_call = 1'b0; ret_return = 1'b0;
      ret_load = 1'b0; cmp_hit = '0;
      case (lvl)
         0:       flow = 1'b1;
         2:       flow = (sv[2] && cl) || (sv[0] && rt);
         default: flow = (sv[2] && tk) || (sv[0] && rt);
      endcase
      if (run_e != 0) begin
         if (flow && lvl == 3) push(2, cyc_e);
         if (flow) push(0, pc);
         if (sv[1] && ld) push(1, ldv);
         if ((hit & mask) != 0) push(3, pc);
         tick(flow);
      end else begin
         tick(1'b0);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick(1'b0);
      end
   endtask

   task automatic check_count(input string rq);
      wr_cmd(8);
      chk(item_count == CW'(smp_e), rq, "item_count", item_count, smp_e);
   endtask

   task automatic read_at(input int i);
      rd_en = 1'b1;
      rd_idx = AW'(i);
      @(negedge clk);
      rd_en = 1'b0;
      tick(1'b0);
   endtask

   task automatic check_buf(input string rq);
      for (int i = 0; i < mcnt; i++) begin
         int j;
         j = (mtot - mcnt + i) % 1024;
         read_at(i);
         chk(rd_kind == 2'(mk[j]), rq, "rd_kind", rd_kind, mk[j]);
         chk(rd_payload == 32'(mp[j]), rq, "rd_payload", rd_payload, mp[j]);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state, nothing stored before start
      chk(item_count == 0, "R1", "item_count", item_count, 0);
      chk(halt_req == 1'b0, "R1", "halt_req", halt_req, 0);
      chk(brk_halt == 1'b0, "R1", "brk_halt", brk_halt, 0);
      retire(32'h40, 1'b1, 1'b0, 1'b0, 1'b0, 0, 0);
      check_count("R1");

      // R2 command priorities
      wr_cmd(1 | 2);
      retire(32'h44, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0);
      check_count("R2");
      wr_cmd(2 | 4);
      retire(32'h48, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0);
      check_count("R2");
      wr_cmd(2);
      retire(32'h4c, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0);
      wr_cmd(4);
      retire(32'h50, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0);
      check_count("R2");
      chk(smp_e == 1, "R2", "model count", smp_e, 1);

      // R4 R5 R6 R7 R8 R12: sweep levels, filters and all flag patterns
      for (int l = 0; l < 4; l++) begin
         for (int s = 0; s < 8; s++) begin
            wr_ctrl(l, s, 0, 0);
            wr_cmd(1);
            wr_cmd(2);
            for (int f = 0; f < 16; f++) begin
               retire(32'h1000 + 4 * f + 256 * s, f[0], f[1], f[2], f[3],
                      32'hD000_0000 ^ (f * 17 + s), 0);
               if (f % 5 == 0) idle(1);
            end
            wr_cmd(4);
            check_count("R4");
            check_buf(l == 3 ? "R8" : (l == 0 ? "R4" : "R5"));
         end
      end

      // R10 overwrite of the oldest item
      wr_ctrl(0, 0, 0, 0);
      wr_cmd(1);
      wr_cmd(2);
      for (int i = 0; i < 20; i++) retire(32'h100 + 4 * i, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0);
      wr_cmd(4);
      check_count("R10");
      chk(smp_e == DEPTH, "R10", "model count", smp_e, DEPTH);
      read_at(0);
      chk(rd_payload == 32'h100 + 4 * 4, "R10", "oldest payload", rd_payload, 32'h110);
      read_at(DEPTH - 1);
      chk(rd_payload == 32'h100 + 4 * 19, "R10", "newest payload", rd_payload, 32'h14c);

      // R11 halt on full
      wr_ctrl(0, 0, 1, 0);
      wr_cmd(1);
      wr_cmd(2);
      for (int i = 0; i < DEPTH - 1; i++) retire(32'h200 + 4 * i, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0);
      chk(halt_req == 1'b0, "R11", "halt before full", halt_req, 0);
      retire(32'h200 + 4 * (DEPTH - 1), 1'b0, 1'b0, 1'b0, 1'b0, 0, 0);
      chk(halt_req == 1'b1, "R11", "halt at full", halt_req, 1);
      for (int i = 0; i < 4; i++) retire(32'h300 + 4 * i, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0);
      wr_cmd(4);
      check_count("R11");
      read_at(DEPTH - 1);
      chk(rd_payload == 32'h200 + 4 * (DEPTH - 1), "R11", "last kept", rd_payload,
          32'h200 + 4 * (DEPTH - 1));
      chk(halt_req == 1'(halt_e), "R11", "halt sticky", halt_req, halt_e);

      // R8 cycle item payload
      wr_ctrl(3, 4, 0, 0);
      wr_cmd(1);
      chk(halt_req == 1'b0, "R2", "halt after clear", halt_req, 0);
      wr_cmd(2);
      idle(7);
      retire(32'h5000, 1'b1, 1'b0, 1'b0, 1'b0, 0, 0);
      wr_cmd(4);
      read_at(0);
      chk(rd_kind == 2'd2 && rd_payload == 32'd7, "R8", "cycle item", rd_payload, 7);
      read_at(1);
      chk(rd_kind == 2'd0 && rd_payload == 32'h5000, "R8", "pc item", rd_payload, 32'h5000);

      // R8 R11 counter overflow raises halt
      wr_ctrl(3, 4, 1, 0);
      wr_cmd(1);
      wr_cmd(2);
      idle(CMAX);
      chk(halt_req == 1'b0, "R8", "halt at saturation", halt_req, 0);
      idle(1);
      chk(halt_req == 1'b1, "R11", "halt on overflow", halt_req, 1);
      wr_cmd(4 | 1);
      chk(halt_req == 1'b0, "R2", "halt cleared", halt_req, 0);

      // R9 tracepoint versus breakpoint
      wr_ctrl(2, 0, 0, 1 << 3);
      wr_cmd(1);
      wr_cmd(2);
      retire(32'h6000, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1 << 3);
      chk(brk_halt == 1'b0, "R9", "brk on tracepoint", brk_halt, 0);
      retire(32'h6004, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1 << 5);
      chk(brk_halt == 1'b1, "R9", "brk on plain hit", brk_halt, 1);
      idle(1);
      chk(brk_halt == 1'b0, "R9", "brk drops", brk_halt, 0);
      wr_cmd(4);
      check_count("R9");
      read_at(0);
      chk(rd_kind == 2'd3 && rd_payload == 32'h6000, "R9", "tp item", rd_payload, 32'h6000);

      // R12 four items from one retirement
      wr_ctrl(3, 7, 0, 1);
      wr_cmd(1);
      wr_cmd(2);
      idle(2);
      retire(32'h7000, 1'b1, 1'b0, 1'b0, 1'b1, 32'hCAFE, 1);
      wr_cmd(4);
      check_count("R12");
      read_at(0);
      chk(rd_kind == 2'd2 && rd_payload == 32'd2, "R12", "slot0 cycle", rd_payload, 2);
      read_at(1);
      chk(rd_kind == 2'd0 && rd_payload == 32'h7000, "R12", "slot1 pc", rd_payload, 32'h7000);
      read_at(2);
      chk(rd_kind == 2'd1 && rd_payload == 32'hCAFE, "R12", "slot2 data", rd_payload, 32'hCAFE);
      read_at(3);
      chk(rd_kind == 2'd3 && rd_payload == 32'h7000, "R12", "slot3 tp", rd_payload, 32'h7000);
      check_buf("R12");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule